// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a single-level data cache placed between a processor load/store port and a plain word-wide main-memory port. It covers a 16-bit byte address space. Its storage is 128 frames of four 32-bit words each, organised as 64 sets of two ways. Every access looks up both ways of the addressed set in parallel. A hit reads or updates one word in the same cycle.

A miss stalls the processor. The cache picks a victim way in the set. If that frame holds modified data, it copies the frame back to memory first. It then fetches the whole requested block one word per handshake. After the fetch the held request completes as a hit. Stores never go to memory directly. They mark the frame dirty, and memory sees the data only when that frame is evicted. When a set has an empty way, that way is filled. When both ways are occupied, a free-running pseudo-random sequence picks between them.

Top module: `wb2way_cache`

## Requirements
- R1: The processor address is decoded as word select = bits [3:2], set index = bits [9:4] and tag = bits [15:10]. Bits [1:0] have no effect, so addresses that differ only there return the same word.
- R2: Both ways of the indexed set are compared at once, and at most one way matches. On a hit, cpu_stall is low in the same cycle and cpu_rdata carries the addressed word. A hit moves no memory beats.
- R3: On a miss, cpu_stall stays high until the refill has completed. The refill reads exactly four beats at byte addresses {tag, index, beat, 2'b00}, with beat 0, 1, 2, 3 in that order. The held request then completes as a hit in the cycle after the last beat.
- R4: A store hit writes only the cached word and marks the frame dirty. No memory write occurs, either in that cycle or in the next.
- R5: A dirty victim is written back before the refill. The write-back is four beats in ascending order at {victim tag, index, beat, 2'b00} and carries the frame's current contents. No write beat occurs once the refill reads have begun.
- R6: A clean victim is dropped, and its miss causes zero memory write beats.
- R7: An invalid way in the indexed set is always filled before any valid block is evicted. Two blocks with the same index and different tags can therefore reside together after reset.
- R8: When both ways are valid, the victim is chosen by the low bit of a free-running 8-bit maximal-length LFSR. Over repeated misses, either way can be evicted.
- R9: A store miss allocates. The block is fetched first and the store word is merged afterwards. The other three words of the block hold memory's contents, and the frame ends up dirty.
- R10: Reset clears every valid and dirty flag. Every access after reset misses, and data that was only in the cache before reset is never written to memory.
- R11: A memory beat completes in a cycle in which mem_req and mem_ready are both high. While mem_req is high and mem_ready is low, the request, its direction and its address are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | High while the access cannot complete this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | 16 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, sampled when the beat completes |
| mem_ready | input | 1 | Memory accepts or supplies the current beat |

## Verification
Two functions meet in one miss: deciding to write back the dirty victim, and starting the refill for the new tag in the same set. The bench makes both ways of a set dirty with stores and then loads a third tag there. Whichever way the random choice evicts, the result is judged the same way. Exactly four write beats, in ascending order, must carry that frame's merged store data to its own old address before the four refill reads. Both displaced stores must still read back correctly afterwards.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W      = 16;
    localparam int WORD_W      = 32;
    localparam int BLOCK_WORDS = 4;
    localparam int SETS        = 64;
    localparam int WAYS        = 2;
    localparam int LFSR_W      = 8;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(BLOCK_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        tag_t              tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [BYTE_W-1:0] bsel;
    } addr_t;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_EVICT,
        CS_FILL
    } cstate_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction
endpackage

// File: rtl/cache_lookup.sv
module cache_lookup
    import cache_pkg::*;
(
    input  tag_t             way_tag [WAYS],
    input  logic [WAYS-1:0]  way_valid,
    input  tag_t             req_tag,
    output logic [WAYS-1:0]  way_hit,
    output logic             any_hit,
    output logic [WAY_W-1:0] hit_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit = |way_hit;
endmodule

// File: rtl/cache_victim.sv
module cache_victim
    import cache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAYS-1:0]  way_dirty,
    output logic [WAY_W-1:0] pick,
    output logic             pick_dirty
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              found;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= LFSR_W'(1);
        else     lfsr_q <= lfsr_step(lfsr_q);
    end

    always_comb begin
        pick  = lfsr_q[WAY_W-1:0];
        found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_valid[w]) begin
                pick  = WAY_W'(w);
                found = 1'b1;
            end
        end
    end

    assign pick_dirty = way_valid[pick] && way_dirty[pick];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              hit,
    input  logic [WAY_W-1:0]  pick,
    input  logic              pick_dirty,
    input  logic              mem_ready,
    output cstate_t           state,
    output logic [WSEL_W-1:0] beat,
    output logic [WAY_W-1:0]  way,
    output logic              fire,
    output logic              last
);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(BLOCK_WORDS - 1);

    assign fire = (state != CS_IDLE) && mem_ready;
    assign last = fire && (beat == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            beat  <= '0;
            way   <= '0;
        end else begin
            case (state)
                CS_IDLE: begin
                    if (cpu_req && !hit) begin
                        way   <= pick;
                        beat  <= '0;
                        state <= pick_dirty ? CS_EVICT : CS_FILL;
                    end
                end
                CS_EVICT: begin
                    if (fire) begin
                        beat <= beat + 1'b1;
                        if (last) state <= CS_FILL;
                    end
                end
                CS_FILL: begin
                    if (fire) begin
                        beat <= beat + 1'b1;
                        if (last) state <= CS_IDLE;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
    import cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready
);
    addr_t a;
    assign a = addr_t'(cpu_addr);

    tag_t            tag_mem  [WAYS][SETS];
    word_t           data_mem [WAYS][SETS][BLOCK_WORDS];
    logic [SETS-1:0] valid_q  [WAYS];
    logic [SETS-1:0] dirty_q  [WAYS];

    tag_t              set_tag [WAYS];
    logic [WAYS-1:0]   set_valid, set_dirty, way_hit;
    logic              hit, pick_dirty, fire, last, busy, valid_any;
    logic [WAY_W-1:0]  hit_way, pick, way;
    logic [WSEL_W-1:0] beat;
    cstate_t           state;

    for (genvar w = 0; w < WAYS; w++) begin : g_set
        assign set_tag[w]   = tag_mem[w][a.idx];
        assign set_valid[w] = valid_q[w][a.idx];
        assign set_dirty[w] = dirty_q[w][a.idx];
    end

    cache_lookup u_lookup (
        .way_tag(set_tag), .way_valid(set_valid), .req_tag(a.tag),
        .way_hit(way_hit), .any_hit(hit), .hit_way(hit_way)
    );

    cache_victim u_victim (
        .clk(clk), .rst(rst), .way_valid(set_valid), .way_dirty(set_dirty),
        .pick(pick), .pick_dirty(pick_dirty)
    );

    cache_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .hit(hit), .pick(pick),
        .pick_dirty(pick_dirty), .mem_ready(mem_ready), .state(state),
        .beat(beat), .way(way), .fire(fire), .last(last)
    );

    logic fill_fire, fill_last, store_hit;
    assign busy      = (state != CS_IDLE);
    assign fill_fire = fire && (state == CS_FILL);
    assign fill_last = last && (state == CS_FILL);
    assign store_hit = !busy && cpu_req && cpu_we && hit;

    always_ff @(posedge clk) begin
        if (fill_fire) data_mem[way][a.idx][beat] <= mem_rdata;
        if (fill_last) tag_mem[way][a.idx] <= a.tag;
        if (store_hit) data_mem[hit_way][a.idx][a.wsel] <= cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) begin
                valid_q[w] <= '0;
                dirty_q[w] <= '0;
            end
        end else begin
            if (fill_last) begin
                valid_q[way][a.idx] <= 1'b1;
                dirty_q[way][a.idx] <= 1'b0;
            end
            if (store_hit) dirty_q[hit_way][a.idx] <= 1'b1;
        end
    end

    always_comb begin
        valid_any = 1'b0;
        for (int w = 0; w < WAYS; w++) valid_any = valid_any | (|valid_q[w]);
    end

    assign cpu_rdata = data_mem[hit_way][a.idx][a.wsel];
    assign cpu_stall = busy || (cpu_req && !hit);

    assign mem_req   = busy;
    assign mem_we    = (state == CS_EVICT);
    assign mem_wdata = data_mem[way][a.idx][beat];
    assign mem_addr  = (state == CS_EVICT)
                     ? {tag_mem[way][a.idx], a.idx, beat, BYTE_W'(0)}
                     : {a.tag, a.idx, beat, BYTE_W'(0)};
endmodule

// File: rtl/cache_chk.sv
module cache_chk
    import cache_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cpu_req,
    input logic            cpu_stall,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ready,
    input logic [15:0]     mem_addr,
    input logic            busy,
    input logic            hit,
    input logic [WAYS-1:0] way_hit,
    input logic            valid_any
);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    fill_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_we);

    // R3
    refill_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && cpu_req) |-> !cpu_stall);

    // R2
    one_way_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    // R4
    store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && hit && !busy) |=> !mem_req);

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !valid_any);
endmodule

bind wb2way_cache cache_chk i_cache_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .busy(busy), .hit(hit), .way_hit(way_hit),
    .valid_any(valid_any)
);

// File: tb/test_wb2way_cache.sv
`timescale 1ns/1ps
module test_wb2way_cache;
    logic        clk = 1'b0, rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata;
    logic        cpu_stall, mem_req, mem_we, mem_ready = 1'b0;
    logic [15:0] mem_addr;

    always #2 clk = ~clk;

    wb2way_cache i_wb2way_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    // memory model
    logic [31:0] mem_model [16384];
    logic [31:0] shadow    [16384];
    logic [15:0] rd_log [4], wr_log [4];
    int rd_beats = 0, wr_beats = 0, rdy_cnt = 0;
    int n_checks = 0, n_err = 0;
    logic [31:0] last_rd;
    int last_stalls;

    assign mem_rdata = mem_model[mem_addr[15:2]];

    always @(negedge clk) begin
        rdy_cnt++;
        mem_ready = (rdy_cnt % 3) != 0;
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ready) begin
            if (mem_we) begin
                mem_model[mem_addr[15:2]] = mem_wdata;
                wr_log[wr_beats % 4] = mem_addr;
                wr_beats++;
            end else begin
                rd_log[rd_beats % 4] = mem_addr;
                rd_beats++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16384; i++) shadow[i] = mem_model[i];
    endtask

    task automatic access(input logic we, input logic [15:0] addr, input logic [31:0] wd);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        last_stalls = 0;
        #1;
        while (cpu_stall && last_stalls < 1000) begin
            last_stalls++;
            @(negedge clk); #1;
        end
        last_rd = cpu_rdata;
        @(posedge clk);
        if (we) shadow[addr[15:2]] = wd;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wd;
        logic        miss;
        logic [2:0]  rb;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 16'h0034, 32'h0,         1'b1, 3'd4},  // R3 first miss
        '{1'b0, 16'h0038, 32'h0,         1'b0, 3'd0},  // R2 hit
        '{1'b1, 16'h003C, 32'hDEADBEEF,  1'b0, 3'd0},  // R4 store hit
        '{1'b0, 16'h003C, 32'h0,         1'b0, 3'd0},  // R4 readback
        '{1'b0, 16'h003E, 32'h0,         1'b0, 3'd0},  // R1 byte bits ignored
        '{1'b0, 16'h0430, 32'h0,         1'b1, 3'd4},  // R7 second tag, set 3
        '{1'b0, 16'h0030, 32'h0,         1'b0, 3'd0},  // R7 first tag resident
        '{1'b1, 16'h0C74, 32'hCAFEF00D,  1'b1, 3'd4},  // R9 store miss
        '{1'b0, 16'h0C74, 32'h0,         1'b0, 3'd0},  // R9 merged word
        '{1'b0, 16'h0C78, 32'h0,         1'b0, 3'd0}   // R9 fetched word
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        int rb0, wb0, ev_a;
        for (int i = 0; i < 16384; i++) mem_model[i] = 32'hC0DE0000 + i;
        do_reset();

        // R10 reset state
        #1;
        chk(!cpu_stall && !mem_req, "R10 reset idle", {30'b0, cpu_stall, mem_req}, 32'h0);
        @(negedge clk);

        // table walk
        for (int v = 0; v < 10; v++) begin
            rb0 = rd_beats; wb0 = wr_beats;
            access(VECS[v].we, VECS[v].addr, VECS[v].wd);
            chk((last_stalls != 0) == VECS[v].miss, "R2/R3 hit-miss", last_stalls, VECS[v].miss);
            chk(rd_beats - rb0 == int'(VECS[v].rb), "R3 refill beats", rd_beats - rb0, VECS[v].rb);
            chk(wr_beats == wb0, "R4/R6 no write beats", wr_beats - wb0, 0);
            if (!VECS[v].we)
                chk(last_rd == shadow[VECS[v].addr[15:2]], "R1/R2/R9 read data", last_rd, shadow[VECS[v].addr[15:2]]);
            if (v == 0)
                for (int i = 0; i < 4; i++)
                    chk(rd_log[i] == 16'h0030 + 16'(4 * i), "R3 refill order", rd_log[i], 16'h0030 + 16'(4 * i));
        end

        // R5 dirty victim write-back, set 5
        access(1'b1, 16'h0854, 32'h11111111);
        access(1'b1, 16'h1058, 32'h22222222);
        rb0 = rd_beats; wb0 = wr_beats;
        access(1'b0, 16'h1850, 32'h0);
        chk(wr_beats - wb0 == 4, "R5 write-back beats", wr_beats - wb0, 4);
        chk(rd_beats - rb0 == 4, "R5 refill after write-back", rd_beats - rb0, 4);
        chk(wr_log[0] == 16'h0850 || wr_log[0] == 16'h1050, "R5 victim address", wr_log[0], 16'h0850);
        for (int i = 1; i < 4; i++)
            chk(wr_log[i] == wr_log[0] + 16'(4 * i), "R5 write-back order", wr_log[i], wr_log[0] + 16'(4 * i));
        if (wr_log[0] == 16'h0850)
            chk(mem_model[16'h0854 >> 2] == 32'h11111111, "R5 write-back data", mem_model[16'h0854 >> 2], 32'h11111111);
        else
            chk(mem_model[16'h1058 >> 2] == 32'h22222222, "R5 write-back data", mem_model[16'h1058 >> 2], 32'h22222222);
        chk(last_rd == shadow[16'h1850 >> 2], "R5 new block data", last_rd, shadow[16'h1850 >> 2]);
        access(1'b0, 16'h0854, 32'h0);
        chk(last_rd == 32'h11111111, "R5 store survives", last_rd, 32'h11111111);
        access(1'b0, 16'h1058, 32'h0);
        chk(last_rd == 32'h22222222, "R5 store survives", last_rd, 32'h22222222);

        // R6 clean victim, set 9
        access(1'b0, 16'h0490, 32'h0);
        access(1'b0, 16'h0890, 32'h0);
        rb0 = rd_beats; wb0 = wr_beats;
        access(1'b0, 16'h0C90, 32'h0);
        chk(wr_beats == wb0, "R6 clean victim no write", wr_beats - wb0, 0);
        chk(rd_beats - rb0 == 4, "R6 refill beats", rd_beats - rb0, 4);

        // R8 random victim over sets 32..47
        ev_a = 0;
        for (int s = 32; s < 48; s++) begin
            wb0 = wr_beats;
            access(1'b0, 16'((1 << 10) | (s << 4)), 32'h0);
            access(1'b0, 16'((2 << 10) | (s << 4)), 32'h0);
            access(1'b0, 16'((3 << 10) | (s << 4)), 32'h0);
            access(1'b0, 16'((1 << 10) | (s << 4)), 32'h0);
            if (last_stalls != 0) ev_a++;
            chk(wr_beats == wb0, "R8 clean trial no write", wr_beats - wb0, 0);
        end
        chk(ev_a > 0 && ev_a < 16, "R8 both ways chosen", ev_a, 8);

        // R10 dirty data dropped by reset, set 12
        access(1'b1, 16'h00C4, 32'h33333333);
        do_reset();
        rb0 = rd_beats; wb0 = wr_beats;
        access(1'b0, 16'h00C4, 32'h0);
        chk(last_stalls != 0, "R10 miss after reset", last_stalls, 1);
        chk(wr_beats == wb0, "R10 no write-back after reset", wr_beats - wb0, 0);
        chk(last_rd == 32'hC0DE0000 + 32'(16'h00C4 >> 2), "R10 memory value", last_rd, 32'hC0DE0000 + 32'(16'h00C4 >> 2));
        chk(rd_beats - rb0 == 4, "R11 four handshake beats", rd_beats - rb0, 4);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule